// File: doc/BRIEF.md
# Serial Control Register Bank

This block is the control port of a mixed-signal audio device. It acts as a two-wire serial bus (I2C) target and holds seven 8-bit write registers: control, select, input, output, left volume, right volume and power. Each value drives the analog side directly. A controller addresses the block with the write address. It then sends a subaddress byte, followed by one or more data bytes. A subaddress pattern chooses whether the register pointer steps forward after each byte or stays on one register. One subaddress code is an alias that loads both volume registers with the same byte in one write.

The read address returns a single status byte at once, with no subaddress phase. The status byte carries two status inputs supplied by the surrounding logic and a power-on flag. The block samples the bus lines with its own fast clock. It detects START and STOP conditions from the sampled levels. It drives the data line through a pull-low enable, so the open-drain pad lies outside the block.

Top module: `i2cb_ctrl_bank`

## Requirements
- R1: The block acknowledges address byte B8h (write) and B9h (read), 7-bit address 1011100, by driving `sda_oe_o` high in the acknowledge slot. For any other address it leaves the line released, and no register changes until the next START.
- R2: In a write transfer the first data byte is a subaddress. A subaddress 0000_0ccc sets the pointer to code ccc. Each following byte is written to the register at the pointer, and the pointer then steps by one.
- R3: A stepping pointer moves from code 7 back to code 0.
- R4: A subaddress 1111_0ccc sets the pointer to ccc without stepping, so every following byte goes to the same register.
- R5: Codes 0 to 5 and 7 select control, select, input, output, left volume, right volume and power. Code 6 writes the same byte to both left and right volume.
- R6: The byte returned after B9h is {calibration input, auto-detect input, power-on flag, 5'b00000}, MSB first. It is sent again for each byte the controller acknowledges.
- R7: The power-on flag is 1 after every reset. It clears once a full status byte has been shifted out.
- R8: While reset is asserted, the registers take the values control 03h, select 00h, input 40h, output 08h, left volume 00h, right volume 00h, power 00h.
- R9: A repeated START or a STOP ends the transfer. In the next write transfer, the first byte after B8h is treated as a subaddress again.
- R10: After a subaddress that matches neither pattern, the data bytes are still acknowledged but no register changes.
- R11: `sda_oe_o` is low while the block is idle or ignoring a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | Pull the data line low when 1 |
| cal_stat_i | input | 1 | Calibration status, returned in status bit 7 |
| auto_stat_i | input | 1 | Auto-detect status, returned in status bit 6 |
| ctrl_o | output | 8 | Control register (code 0) |
| sel_o | output | 8 | Select register (code 1) |
| inp_o | output | 8 | Input register (code 2) |
| outp_o | output | 8 | Output register (code 3) |
| vol_l_o | output | 8 | Left volume register (code 4) |
| vol_r_o | output | 8 | Right volume register (code 5) |
| pwr_o | output | 8 | Power register (code 7) |

## Verification
The hardest case to reach from the ports is a repeated START in the middle of a write. The byte that follows the new address must be taken as a subaddress, not as data for the register the old pointer still selects. The stimulus sends a write with a data byte, issues a repeated START without a STOP, and then sends a byte. That byte would land on the next register if it were taken as data. The power-on flag is also hard to reach, because it is set only by reset. The bench therefore asserts reset in the middle of the run and reads the status byte again.

// File: rtl/i2cb_pkg.sv
`timescale 1ns/1ps
package i2cb_pkg;
  localparam int DW         = 8;
  localparam int NREG       = 7;
  localparam int PTRW       = 3;
  localparam int CNTW       = 4;
  localparam int ALIAS_CODE = 6;
  localparam int VOL_L_SLOT = 4;
  localparam int VOL_R_SLOT = 5;
  localparam logic [6:0] DEV_ADDR = 7'b1011100;
  localparam logic [DW-PTRW-1:0] SUB_STEP = '0;
  localparam logic [DW-PTRW-1:0] SUB_HOLD = 5'b11110;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_AACK, LS_WDAT, LS_WACK, LS_RDAT, LS_RACK, LS_SKIP
  } link_st_e;

  function automatic logic [DW-1:0] slot_default(int slot);
    case (slot)
      0:       return 8'h03;
      2:       return 8'h40;
      3:       return 8'h08;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/i2cb_pin_sync.sv
`timescale 1ns/1ps
module i2cb_pin_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe, scl_pipe_n;
  logic [PW-1:0] sda_pipe, sda_pipe_n;
  logic scl_now, scl_prev, sda_now, sda_prev;

  always_comb begin
    scl_pipe_n = {scl_pipe[PW-2:0], scl_i};
    sda_pipe_n = {sda_pipe[PW-2:0], sda_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
    end
  end

  assign scl_now  = scl_pipe[PW-2];
  assign scl_prev = scl_pipe[PW-1];
  assign sda_now  = sda_pipe[PW-2];
  assign sda_prev = sda_pipe[PW-1];

  assign sda_q     = sda_now;
  assign scl_rise  = scl_now & ~scl_prev;
  assign scl_fall  = ~scl_now & scl_prev;
  assign start_det = scl_now & scl_prev & sda_prev & ~sda_now;
  assign stop_det  = scl_now & scl_prev & ~sda_prev & sda_now;
endmodule

// File: rtl/i2cb_link.sv
`timescale 1ns/1ps
module i2cb_link
  import i2cb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_q,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic [DW-1:0] status_byte,
  output logic          sda_oe,
  output logic          byte_stb,
  output logic          byte_is_sub,
  output logic [DW-1:0] byte_val,
  output logic          status_done,
  output logic          idle
);
  localparam logic [CNTW-1:0] FULL = CNTW'(DW);

  link_st_e        st, st_n;
  logic [CNTW-1:0] cnt, cnt_n;
  logic [DW-1:0]   sh, sh_n;
  logic            rw, rw_n;
  logic            first, first_n;
  logic            oe, oe_n;
  logic            mack, mack_n;

  always_comb begin
    st_n    = st;
    cnt_n   = cnt;
    sh_n    = sh;
    rw_n    = rw;
    first_n = first;
    oe_n    = oe;
    mack_n  = mack;
    if (stop_det) begin
      st_n = LS_IDLE;
      oe_n = 1'b0;
    end else if (start_det) begin
      st_n    = LS_ADDR;
      cnt_n   = '0;
      oe_n    = 1'b0;
      first_n = 1'b1;
    end else begin
      case (st)
        LS_ADDR: begin
          if (scl_rise) begin
            sh_n  = {sh[DW-2:0], sda_q};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            if (sh[DW-1:1] == DEV_ADDR) begin
              st_n = LS_AACK;
              rw_n = sh[0];
              oe_n = 1'b1;
            end else begin
              st_n = LS_SKIP;
            end
          end
        end
        LS_AACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (rw) begin
              st_n = LS_RDAT;
              sh_n = status_byte;
              oe_n = ~status_byte[DW-1];
            end else begin
              st_n = LS_WDAT;
              oe_n = 1'b0;
            end
          end
        end
        LS_WDAT: begin
          if (scl_rise) begin
            sh_n  = {sh[DW-2:0], sda_q};
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL) begin
            st_n    = LS_WACK;
            oe_n    = 1'b1;
            first_n = 1'b0;
          end
        end
        LS_WACK: begin
          if (scl_fall) begin
            st_n  = LS_WDAT;
            cnt_n = '0;
            oe_n  = 1'b0;
          end
        end
        LS_RDAT: begin
          if (scl_rise) begin
            cnt_n = cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == FULL) begin
              st_n = LS_RACK;
              oe_n = 1'b0;
            end else begin
              sh_n = {sh[DW-2:0], 1'b0};
              oe_n = ~sh[DW-2];
            end
          end
        end
        LS_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_q;
          end else if (scl_fall) begin
            if (mack) begin
              st_n  = LS_RDAT;
              cnt_n = '0;
              sh_n  = status_byte;
              oe_n  = ~status_byte[DW-1];
            end else begin
              st_n = LS_SKIP;
            end
          end
        end
        default: oe_n = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= LS_IDLE;
      cnt   <= '0;
      sh    <= '0;
      rw    <= 1'b0;
      first <= 1'b1;
      oe    <= 1'b0;
      mack  <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      sh    <= sh_n;
      rw    <= rw_n;
      first <= first_n;
      oe    <= oe_n;
      mack  <= mack_n;
    end
  end

  assign sda_oe      = oe;
  assign byte_stb    = (st == LS_WDAT) && scl_fall && (cnt == FULL) && !stop_det && !start_det;
  assign byte_is_sub = first;
  assign byte_val    = sh;
  assign status_done = (st == LS_RDAT) && scl_fall && (cnt == FULL) && !stop_det && !start_det;
  assign idle        = (st == LS_IDLE) || (st == LS_SKIP);
endmodule

// File: rtl/i2cb_regfile.sv
`timescale 1ns/1ps
module i2cb_regfile
  import i2cb_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      byte_stb,
  input  logic                      byte_is_sub,
  input  logic [DW-1:0]             byte_val,
  output logic [NREG-1:0][DW-1:0]   regs_o,
  output logic [PTRW-1:0]           ptr_o,
  output logic                      ptr_inc_o,
  output logic                      ptr_ok_o
);
  logic [PTRW-1:0] ptr, ptr_n;
  logic            inc, inc_n;
  logic            ok, ok_n;
  logic            sub_go, wr_go;

  assign sub_go = byte_stb && byte_is_sub;
  assign wr_go  = byte_stb && !byte_is_sub && ok;

  always_comb begin
    ptr_n = ptr;
    inc_n = inc;
    ok_n  = ok;
    if (sub_go) begin
      ptr_n = byte_val[PTRW-1:0];
      if (byte_val[DW-1:PTRW] == SUB_STEP) begin
        inc_n = 1'b1;
        ok_n  = 1'b1;
      end else if (byte_val[DW-1:PTRW] == SUB_HOLD) begin
        inc_n = 1'b0;
        ok_n  = 1'b1;
      end else begin
        ok_n  = 1'b0;
      end
    end else if (wr_go && inc) begin
      ptr_n = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      inc <= 1'b1;
      ok  <= 1'b0;
    end else begin
      ptr <= ptr_n;
      inc <= inc_n;
      ok  <= ok_n;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    localparam int CODE_I = (g < ALIAS_CODE) ? g : g + 1;
    localparam logic [PTRW-1:0] CODE = CODE_I[PTRW-1:0];
    localparam bit IS_VOL = (g == VOL_L_SLOT) || (g == VOL_R_SLOT);
    localparam logic [PTRW-1:0] ALIAS = ALIAS_CODE[PTRW-1:0];
    logic          we;
    logic [DW-1:0] slot_q, slot_n;

    always_comb begin
      we     = wr_go && ((ptr == CODE) || (IS_VOL && ptr == ALIAS));
      slot_n = we ? byte_val : slot_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slot_q <= slot_default(g);
      else        slot_q <= slot_n;
    end

    assign regs_o[g] = slot_q;
  end

  assign ptr_o     = ptr;
  assign ptr_inc_o = inc;
  assign ptr_ok_o  = ok;
endmodule

// File: rtl/i2cb_ctrl_bank.sv
`timescale 1ns/1ps
module i2cb_ctrl_bank
  import i2cb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          cal_stat_i,
  input  logic          auto_stat_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] sel_o,
  output logic [DW-1:0] inp_o,
  output logic [DW-1:0] outp_o,
  output logic [DW-1:0] vol_l_o,
  output logic [DW-1:0] vol_r_o,
  output logic [DW-1:0] pwr_o
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic sda_oe, byte_stb, byte_is_sub, status_done, link_idle;
  logic [DW-1:0] byte_val, status_byte;
  logic [NREG-1:0][DW-1:0] regs_w;
  logic [PTRW-1:0] ptr_w;
  logic ptr_inc_w, ptr_ok_w;
  logic por_q, por_n;

  i2cb_pin_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cb_link u_link (
    .clk(clk), .rst_n(rst_sync_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .status_byte(status_byte), .sda_oe(sda_oe), .byte_stb(byte_stb),
    .byte_is_sub(byte_is_sub), .byte_val(byte_val),
    .status_done(status_done), .idle(link_idle)
  );

  i2cb_regfile u_regs (
    .clk(clk), .rst_n(rst_sync_n), .byte_stb(byte_stb),
    .byte_is_sub(byte_is_sub), .byte_val(byte_val), .regs_o(regs_w),
    .ptr_o(ptr_w), .ptr_inc_o(ptr_inc_w), .ptr_ok_o(ptr_ok_w)
  );

  always_comb begin
    por_n = status_done ? 1'b0 : por_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) por_q <= 1'b1;
    else             por_q <= por_n;
  end

  assign status_byte = {cal_stat_i, auto_stat_i, por_q, 5'b00000};
  assign sda_oe_o    = sda_oe;
  assign ctrl_o      = regs_w[0];
  assign sel_o       = regs_w[1];
  assign inp_o       = regs_w[2];
  assign outp_o      = regs_w[3];
  assign vol_l_o     = regs_w[VOL_L_SLOT];
  assign vol_r_o     = regs_w[VOL_R_SLOT];
  assign pwr_o       = regs_w[6];
endmodule

// File: rtl/i2cb_ctrl_bank_chk.sv
`timescale 1ns/1ps
module i2cb_ctrl_bank_chk
  import i2cb_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    byte_stb,
  input logic                    byte_is_sub,
  input logic [PTRW-1:0]         ptr,
  input logic                    ptr_inc,
  input logic                    ptr_ok,
  input logic [NREG-1:0][DW-1:0] regs,
  input logic                    sda_oe,
  input logic                    link_idle,
  input logic                    por_q,
  input logic                    status_done
);
  logic data_go;
  assign data_go = byte_stb && !byte_is_sub;

  a_r2_regs_change_only_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    !data_go |=> $stable(regs));

  a_r10_bad_sub_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && !ptr_ok) |=> $stable(regs));

  a_r5_alias_loads_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && ptr_ok && ptr == PTRW'(ALIAS_CODE)) |=> (regs[VOL_L_SLOT] == regs[VOL_R_SLOT]));

  a_r3_pointer_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && ptr_ok && ptr_inc && ptr == '1) |=> (ptr == '0));

  a_r4_pointer_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (data_go && ptr_ok && !ptr_inc) |=> $stable(ptr));

  a_r7_por_clears_on_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    (por_q && !status_done) |=> por_q);

  a_r7_por_stays_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !por_q |=> !por_q);

  a_r11_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    link_idle |-> !sda_oe);
endmodule

bind i2cb_ctrl_bank i2cb_ctrl_bank_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .byte_stb(byte_stb), .byte_is_sub(byte_is_sub),
  .ptr(ptr_w), .ptr_inc(ptr_inc_w), .ptr_ok(ptr_ok_w), .regs(regs_w),
  .sda_oe(sda_oe), .link_idle(link_idle), .por_q(por_q), .status_done(status_done)
);

// File: tb/tb_i2cb_ctrl_bank.sv
`timescale 1ns/1ps
module tb_i2cb_ctrl_bank;
  localparam int Q = 6;
  localparam int NV = 9;
  // {subaddress, data0, data1}
  localparam logic [23:0] VEC [0:NV-1] = '{
    24'h00_A1_B2, 24'h03_C4_D5, 24'h07_11_22, 24'h06_3C_5E, 24'hF2_5A_6B,
    24'hF6_77_88, 24'h05_99_AA, 24'h42_EE_FF, 24'hF7_01_02
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, scl_m, sda_m, cal, autod;
  logic sda_oe;
  logic [7:0] ctrl, sel, inp, outp, voll, volr, pwr;
  wire sda_line = sda_m & ~sda_oe;

  i2cb_ctrl_bank dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .cal_stat_i(cal), .auto_stat_i(autod), .ctrl_o(ctrl), .sel_o(sel),
    .inp_o(inp), .outp_o(outp), .vol_l_o(voll), .vol_r_o(volr), .pwr_o(pwr)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_r [0:7];
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  function automatic logic [7:0] reg_at(input int code);
    case (code)
      0: return ctrl;
      1: return sel;
      2: return inp;
      3: return outp;
      4: return voll;
      5: return volr;
      default: return pwr;
    endcase
  endfunction

  task automatic load_defaults();
    exp_r[0] = 8'h03; exp_r[1] = 8'h00; exp_r[2] = 8'h40; exp_r[3] = 8'h08;
    exp_r[4] = 8'h00; exp_r[5] = 8'h00; exp_r[6] = 8'h00; exp_r[7] = 8'h00;
  endtask

  task automatic model_write(input int code, input logic [7:0] d);
    if (code == 6) begin exp_r[4] = d; exp_r[5] = d; end
    else exp_r[code] = d;
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < 8; c++) begin
      if (c != 6) chk(req, $sformatf("register code %0d", c), reg_at(c), exp_r[c]);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    ack = ~sda_line;
    scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
      b[i] = sda_line;
      scl_m = 1'b0; wq();
    end
    sda_m = ~mack; wq(); scl_m = 1'b1; wq(); scl_m = 1'b0; wq();
    sda_m = 1'b1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic ack;
    logic [7:0] rb;
    scl_m = 1'b1; sda_m = 1'b1; cal = 1'b0; autod = 1'b0;
    do_reset();

    // R8: reset values
    load_defaults();
    check_all("R8");
    chk("R11", "oe while idle", {7'd0, sda_oe}, 8'h00);

    // R6 R7: status read, flag set then cleared after one byte
    cal = 1'b1; autod = 1'b0;
    bus_start();
    send_byte(8'hB9, ack);
    chk("R1", "read address ack", {7'd0, ack}, 8'h01);
    recv_byte(1'b1, rb);
    chk("R6", "first status byte", rb, 8'hA0);
    recv_byte(1'b0, rb);
    chk("R7", "status after flag cleared", rb, 8'h80);
    bus_stop();

    // Table of write transfers (R2 R3 R4 R5 R10)
    for (int v = 0; v < NV; v++) begin
      logic [7:0] sub, d0, d1;
      int ptr;
      bit inc, ok;
      sub = VEC[v][23:16]; d0 = VEC[v][15:8]; d1 = VEC[v][7:0];
      bus_start();
      send_byte(8'hB8, ack);
      chk("R1", "write address ack", {7'd0, ack}, 8'h01);
      send_byte(sub, ack);
      send_byte(d0, ack);
      chk("R10", "data byte ack", {7'd0, ack}, 8'h01);
      send_byte(d1, ack);
      bus_stop();
      ptr = int'(sub[2:0]);
      inc = (sub[7:3] == 5'b00000);
      ok  = inc || (sub[7:3] == 5'b11110);
      if (ok) begin
        model_write(ptr, d0);
        if (inc) ptr = (ptr + 1) % 8;
        model_write(ptr, d1);
      end
      check_all($sformatf("R2 R3 R4 R5 R10 vector %0d", v));
      chk("R11", "oe after stop", {7'd0, sda_oe}, 8'h00);
    end

    // R1: foreign address is not acknowledged and writes nothing
    bus_start();
    send_byte(8'hB0, ack);
    chk("R1", "foreign address ack", {7'd0, ack}, 8'h00);
    send_byte(8'h00, ack);
    chk("R11", "ignored byte ack", {7'd0, ack}, 8'h00);
    send_byte(8'h5F, ack);
    bus_stop();
    check_all("R1");

    // R9: repeated start makes the next byte a subaddress again
    bus_start();
    send_byte(8'hB8, ack);
    send_byte(8'h01, ack);
    send_byte(8'h12, ack);
    bus_start();
    send_byte(8'hB8, ack);
    send_byte(8'h02, ack);
    send_byte(8'h34, ack);
    bus_stop();
    model_write(1, 8'h12);
    model_write(2, 8'h34);
    chk("R9", "select after first part", sel, 8'h12);
    chk("R9", "input after restart", inp, 8'h34);
    chk("R9", "output untouched", outp, exp_r[3]);

    // R9: stop also forces a new subaddress
    bus_start();
    send_byte(8'hB8, ack);
    send_byte(8'h03, ack);
    bus_stop();
    bus_start();
    send_byte(8'hB8, ack);
    send_byte(8'h00, ack);
    send_byte(8'h9C, ack);
    bus_stop();
    chk("R9", "control after stop", ctrl, 8'h9C);
    chk("R9", "output after stop", outp, exp_r[3]);

    // R7 R8: reset again mid-run
    do_reset();
    load_defaults();
    check_all("R8 second reset");
    cal = 1'b0; autod = 1'b1;
    bus_start();
    send_byte(8'hB9, ack);
    recv_byte(1'b0, rb);
    bus_stop();
    chk("R7", "flag set after reset", rb, 8'h60);
    chk("R11", "oe at end", {7'd0, sda_oe}, 8'h00);

    finish_run();
  end
endmodule